// File: doc/BRIEF.md
# Dynamic Memory Refresh Scheduler

This block decides when a dynamic memory array is refreshed and which row is refreshed. After reset it asks for a wake-up burst of refresh cycles. During that burst the rest of the system is told to stay away from the memory. When the burst is over, the block raises a ready flag and switches to a spread-out schedule. In that schedule one row refresh is requested every fixed number of clocks, so that all rows are covered within the retention window.

The memory sequencer sees a level request and answers with a one-cycle acknowledge for each refresh it performs. Each refresh is a row-strobe-only cycle, and the sequencer sends it to every device on the shared control bus at the same time. The row to refresh is a single output that all devices share. If the sequencer is late, requests wait in a small pending counter so that no refresh is lost. If that counter cannot hold another request, an error flag goes high and stays high.

The spacing between requests is the window length in clocks divided by the number of rows, rounded down. This makes the full sweep of rows take no longer than the window.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high, and in the cycle after it, `ref_req`, `sys_ready` and `ref_err` are 0 and `ref_row` is 0.
- R2: From the first cycle after reset, `ref_req` stays at 1 until INIT_CYCLES (default 8) refreshes have been accepted. It does not drop in cycles where `ref_ack` is low.
- R3: `sys_ready` stays at 0 until the INIT_CYCLES-th accepted wake-up refresh. It rises in the cycle after that refresh and never falls again until reset.
- R4: The first periodic request appears INTERVAL = floor(WINDOW_CLKS/ROWS) clock edges after `sys_ready` rises. Each later request appears INTERVAL edges after the one before it.
- R5: A refresh is accepted on a clock edge where `ref_ack` and `ref_req` are both 1. Each accepted refresh moves `ref_row` to the next row, going from ROWS-1 back to 0. At all other times `ref_row` holds its value.
- R6: `ref_ack` has no effect while `ref_req` is 0: `ref_row` and `ref_req` do not change.
- R7: Periodic requests that have not been served add up in a pending count, up to 2^PEND_W-1. `ref_req` stays at 1 while that count is non-zero, and each accepted refresh removes one request from it.
- R8: Suppose a new periodic request and an accepted refresh fall on the same edge. Then the pending count does not change, and `ref_req` stays at 1 if the count was non-zero.
- R9: Suppose a new periodic request arrives when the pending count is full and no refresh is accepted on that edge. Then `ref_err` rises and stays at 1 until reset, and the pending count stays at its maximum.
- R10: If every request is acknowledged at once, ROWS consecutive refreshes cover every row exactly once within ROWS*INTERVAL cycles, which is no more than WINDOW_CLKS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ack | input | 1 | The sequencer performed the requested refresh this cycle |
| ref_req | output | 1 | A refresh is wanted (a level signal) |
| ref_row | output | $clog2(ROWS) | Row to refresh, shared by all devices |
| sys_ready | output | 1 | The wake-up burst is complete and normal accesses may start |
| ref_err | output | 1 | A request was lost because the pending count was full (sticky) |

## Verification
The case that needs care is a periodic request and an accepted acknowledge landing on the same clock edge. In that case the pending count must first add one and then take one away, so that it ends up unchanged. The bench measures the request spacing and then holds the acknowledge back until the edge where the next request is due. The coincidence is judged correct if `ref_req` is still high after that edge, `ref_row` has advanced by exactly one, and a single further acknowledge brings the request low.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic {
    PH_WAKE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/refresh_tick.sv
module refresh_tick #(
  parameter int INTERVAL = 3906
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int ROWS = 128
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int RW = $clog2(ROWS);

  logic [RW-1:0] row_q;
  assign row = row_q;

  generate
    if ((ROWS & (ROWS - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk) begin
        if (rst)      row_q <= '0;
        else if (adv) row_q <= row_q + 1'b1;
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)                              row_q <= '0;
        else if (adv && row_q == RW'(ROWS-1)) row_q <= '0;
        else if (adv)                         row_q <= row_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/refresh_pend.sv
module refresh_pend #(
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] cnt_next,
  output logic              ovf
);
  localparam logic [PEND_W-1:0] FULL = '1;

  logic [PEND_W-1:0] cnt_q;

  always_comb begin
    cnt_next = cnt_q;
    ovf      = 1'b0;
    if (inc && !dec) begin
      if (cnt_q == FULL) ovf = 1'b1;
      else               cnt_next = cnt_q + 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_next = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int ROWS        = 128,
  parameter int WINDOW_CLKS = 500000,
  parameter int INIT_CYCLES = 8,
  parameter int PEND_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ref_ack,
  output logic                    ref_req,
  output logic [$clog2(ROWS)-1:0] ref_row,
  output logic                    sys_ready,
  output logic                    ref_err
);
  localparam int INTERVAL = WINDOW_CLKS / ROWS;
  localparam int IC_W     = $clog2(INIT_CYCLES + 1);

  phase_e            phase_q, phase_d;
  logic [IC_W-1:0]   init_q;
  logic              req_q, err_q;
  logic              served, in_run, tick, ovf;
  logic [PEND_W-1:0] pend_next;

  assign served = req_q && ref_ack;
  assign in_run = (phase_q == PH_RUN);

  always_comb begin
    phase_d = phase_q;
    if (!in_run && served && init_q == IC_W'(INIT_CYCLES - 1)) phase_d = PH_RUN;
  end

  refresh_tick #(.INTERVAL(INTERVAL)) tick_i (
    .clk(clk), .rst(rst), .en(in_run), .tick(tick)
  );

  refresh_pend #(.PEND_W(PEND_W)) pend_i (
    .clk(clk), .rst(rst), .inc(tick), .dec(served && in_run),
    .cnt_next(pend_next), .ovf(ovf)
  );

  refresh_row_ctr #(.ROWS(ROWS)) row_i (
    .clk(clk), .rst(rst), .adv(served), .row(ref_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_WAKE;
      init_q  <= '0;
      req_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (served && !in_run) init_q <= init_q + 1'b1;
      req_q   <= (phase_d == PH_WAKE) || (pend_next != '0);
      err_q   <= err_q || ovf;
    end
  end

  assign ref_req   = req_q;
  assign sys_ready = in_run;
  assign ref_err   = err_q;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int ROWS = 128
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ref_ack,
  input logic                    ref_req,
  input logic [$clog2(ROWS)-1:0] ref_row,
  input logic                    sys_ready,
  input logic                    ref_err
);
  localparam int RW = $clog2(ROWS);

  logic [RW-1:0] row_plus;
  always_comb row_plus = (ref_row == RW'(ROWS - 1)) ? '0 : ref_row + 1'b1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!ref_req && !sys_ready && !ref_err && ref_row == '0));

  // R3
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sys_ready |=> sys_ready);

  // R3
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_ready) |-> $past(ref_req && ref_ack));

  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_ack) |=> ref_row == $past(row_plus));

  // R6
  row_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(ref_req && ref_ack) |=> $stable(ref_row));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_ack) |=> ref_req);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ref_err |=> ref_err);
endmodule

bind refresh_sched refresh_sched_chk #(.ROWS(ROWS)) chk_i (
  .clk(clk), .rst(rst), .ref_ack(ref_ack), .ref_req(ref_req),
  .ref_row(ref_row), .sys_ready(sys_ready), .ref_err(ref_err)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb_top;
  localparam int ROWS     = 16;
  localparam int WINDOW   = 160;
  localparam int INIT     = 8;
  localparam int PEND_W   = 2;
  localparam int INTERVAL = WINDOW / ROWS;
  localparam int PMAX     = (1 << PEND_W) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_ack = 1'b0;
  logic       ref_req, sys_ready, ref_err;
  logic [3:0] ref_row;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  refresh_sched #(.ROWS(ROWS), .WINDOW_CLKS(WINDOW), .INIT_CYCLES(INIT),
                  .PEND_W(PEND_W)) dut_i (
    .clk(clk), .rst(rst), .ref_ack(ref_ack), .ref_req(ref_req),
    .ref_row(ref_row), .sys_ready(sys_ready), .ref_err(ref_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_req(output int cyc);
    cyc = 0;
    while (!ref_req && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ref_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 req", int'(ref_req), 0);
    chk("R1 ready", int'(sys_ready), 0);
    chk("R1 row", int'(ref_row), 0);
    chk("R1 err", int'(ref_err), 0);
    rst = 1'b0;
  endtask

  // Wake-up burst; gaps selects an acknowledge pattern with idle cycles.
  task automatic do_init(input bit gaps);
    int acc = 0;
    bit done = 1'b0;
    for (int k = 0; k < 100 && !done; k++) begin
      @(negedge clk);
      chk("R3 ready", int'(sys_ready), (acc == INIT) ? 1 : 0);
      if (acc == INIT) begin
        done = 1'b1;
        ref_ack = 1'b0;
      end else begin
        chk("R2 req", int'(ref_req), 1);
        chk("R5 row", int'(ref_row), acc % ROWS);
        ref_ack = gaps ? (k % 3 != 2) : 1'b1;
        if (ref_ack && ref_req) acc++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    int er;
    logic [15:0] mask;

    do_reset();
    do_init(1'b1);
    chk("R5 row after burst", int'(ref_row), INIT % ROWS);

    // R6: acknowledge without request is ignored
    ref_ack = 1'b1;
    cyc = 0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      cyc++;
      chk("R6 req", int'(ref_req), 0);
      chk("R6 row", int'(ref_row), INIT % ROWS);
    end
    ref_ack = 1'b0;
    begin
      int c2;
      wait_req(c2);
      cyc += c2;
    end
    chk("R4 first request spacing", cyc, INTERVAL);

    // R4 / R5 / R10: prompt service
    er = INIT % ROWS;
    mask = '0;
    for (int n = 0; n < 20; n++) begin
      chk("R5 row", int'(ref_row), er);
      if (n < ROWS) mask[ref_row] = 1'b1;
      ref_ack = 1'b1;
      @(negedge clk);
      ref_ack = 1'b0;
      chk("R7 retire", int'(ref_req), 0);
      er = (er + 1) % ROWS;
      wait_req(cyc);
      chk("R4 spacing", cyc + 1, INTERVAL);
    end
    chk("R10 coverage", int'(mask), 16'hFFFF);
    chk("R10 window", ROWS * INTERVAL <= WINDOW ? 1 : 0, 1);

    // R7: accumulate to full without overflow
    repeat (2 * INTERVAL) @(negedge clk);
    chk("R7 req held", int'(ref_req), 1);
    chk("R7 err", int'(ref_err), 0);
    ref_ack = 1'b1;
    for (int a = 0; a < PMAX; a++) begin
      @(negedge clk);
      chk("R7 row", int'(ref_row), (er + a + 1) % ROWS);
      chk("R7 req", int'(ref_req), (a < PMAX - 1) ? 1 : 0);
    end
    ref_ack = 1'b0;
    er = (er + PMAX) % ROWS;

    // R8: new request and acknowledge on the same edge
    wait_req(cyc);
    repeat (INTERVAL - 1) @(negedge clk);
    ref_ack = 1'b1;
    @(negedge clk);
    chk("R8 req kept", int'(ref_req), 1);
    chk("R8 row", int'(ref_row), (er + 1) % ROWS);
    @(negedge clk);
    ref_ack = 1'b0;
    chk("R8 req done", int'(ref_req), 0);
    chk("R8 row next", int'(ref_row), (er + 2) % ROWS);
    er = (er + 2) % ROWS;

    // R9: overflow of the pending count
    wait_req(cyc);
    repeat (2 * INTERVAL) @(negedge clk);
    chk("R9 no err at full", int'(ref_err), 0);
    repeat (INTERVAL) @(negedge clk);
    chk("R9 err raised", int'(ref_err), 1);
    ref_ack = 1'b1;
    for (int a = 0; a < PMAX; a++) begin
      @(negedge clk);
      chk("R9 saturated req", int'(ref_req), (a < PMAX - 1) ? 1 : 0);
    end
    ref_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 err sticky", int'(ref_err), 1);

    // Second reset, burst with prompt acknowledge
    do_reset();
    do_init(1'b0);
    chk("R5 row after burst", int'(ref_row), INIT % ROWS);
    chk("R3 ready stays", int'(sys_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule